// File: doc/BRIEF.md
# Frequency and Phase Word Loader

This block sits between a host bus and a numerically controlled oscillator core. The host writes a 40-bit configuration word into a staging register. It can write the word as five byte writes on an 8-bit bus, or as forty single-bit writes on one line of that bus. Each write is marked by a rising edge of a host write clock. A separate update strobe then copies the whole staged word into the active register in one step. The core therefore never sees a half-written frequency or phase.

The 40-bit word has two parts: a 32-bit frequency tuning word and an 8-bit control byte. The control byte holds a 5-bit phase offset, a power-down flag, a loading-format selector and a clock-multiplier enable. The write clock and the update strobe are asynchronous to the system clock. Both pass through synchronizers and rising-edge detectors. The core is told about each applied update by a one-cycle pulse.

Top module: `tuning_loader`

## Requirements
- R1: A system-clock cycle with `rst_n` low clears the staging register, the active register and the byte counter, and selects byte (parallel) loading. All outputs read zero and `upd_pulse` is low.
- R2: In byte loading, the first write after reset or after an update is the control byte. The next four writes are the frequency word, most significant byte first: bits 31:24, then 23:16, then 15:8, then 7:0.
- R3: Control byte layout: bits 7:3 are the phase offset, bit 2 is power-down, bit 1 selects the loading format (0 = byte, 1 = serial), and bit 0 is the multiplier enable.
- R4: Write-clock edges change only the staging register. The outputs keep their values until an update is applied.
- R5: The update strobe's rising edge reaches the system clock domain through a two-flop synchronizer. On the third rising clock edge after the strobe rises, the whole staged word is copied to the outputs, and `upd_pulse` goes high at that same edge for exactly one cycle.
- R6: The byte counter wraps after five writes, so a sixth byte write before an update overwrites the control byte.
- R7: An update clears the byte counter. After a partial byte load and an update, the next write is taken as the control byte again.
- R8: In serial loading, each write-clock edge shifts `din[7]` into the staging register. Forty writes send the frequency word least significant bit first, then the control byte least significant bit first.
- R9: The loading format comes from bit 1 of the most recently applied control byte and holds until another update. In serial loading, `din[6:0]` have no effect.
- R10: Each rising edge of the write clock makes exactly one write, however long the write clock stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_clk | input | 1 | Host write clock, asynchronous; a rising edge makes one write |
| upd_strobe | input | 1 | Host update strobe, asynchronous; a rising edge applies the staged word |
| din | input | 8 | Host data bus; bit 7 is the serial data line |
| freq_word | output | 32 | Active frequency tuning word |
| phase_ofs | output | 5 | Active phase offset |
| pwr_down | output | 1 | Active power-down flag |
| mult_en | output | 1 | Active clock-multiplier enable |
| upd_pulse | output | 1 | One-cycle pulse when a staged word is applied |

## Verification
Each host strobe takes three clock edges to have an effect: two synchronizer flops, then the register that acts on the detected edge. A write is captured at the third edge after `wr_clk` rises. The outputs and `upd_pulse` change at the third edge after `upd_strobe` rises. The bench drives every strobe at a falling clock edge. It checks one cycle before the third edge that the old values and a low pulse are still present. It then checks at the falling edge that follows the third edge that the new word is present and the pulse is high, and one cycle later that the pulse is low again. Each write strobe is held for several cycles and then left low for several cycles, so every write has settled before the next stimulus begins.

// File: rtl/tl_pkg.sv
// Package: shared widths and the layout of the 40-bit configuration word.
// Assumes the control byte sits above the frequency word in the staged word.
package tl_pkg;
    localparam int BYTE_W  = 8;
    localparam int FREQ_W  = 32;
    localparam int PHASE_W = 5;
    localparam int NBYTES  = 5;
    localparam int WORD_W  = NBYTES * BYTE_W;
    localparam int CNT_W   = $clog2(NBYTES);

    // Control byte: phase offset, power-down, format select, multiplier enable.
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               pdn;
        logic               fmt_serial;
        logic               mult;
    } ctrl_t;

    // Full staged/active word: control byte above the frequency word.
    typedef struct packed {
        ctrl_t             ctrl;
        logic [FREQ_W-1:0] freq;
    } word_t;
endpackage

// File: rtl/tl_edge_sync.sv
// Module: brings one asynchronous strobe into the clk domain and flags its rising edge.
// Assumes each high and low phase of the strobe lasts longer than two clk periods.
// The rise output is combinational from the last two flops of the chain.
module tl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain_q;

    // Shift the strobe through the synchronizer chain and keep one extra history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    // Rising edge seen at the synchronized output.
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R10: a detected edge never lasts two cycles.
    p_single_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tl_load_stage.sv
// Module: staging register and byte counter for both loading formats.
// Assumes din is stable for the three clk cycles after the write strobe rises.
// In byte mode the counter picks the slot; in serial mode a single lane shifts in from the top.
module tl_load_stage
    import tl_pkg::*;
#(
    parameter int SER_LANE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic              upd_evt,
    input  logic              serial,
    input  logic [BYTE_W-1:0] din,
    output word_t             stage
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] stage_d;
    logic [CNT_W-1:0]  cnt_q;

    // Next staged word: a serial shift, or a byte placed in the slot the counter picks.
    always_comb begin
        stage_d = stage_q;
        if (wr_evt) begin
            if (serial) begin
                stage_d = {din[SER_LANE], stage_q[WORD_W-1:1]};
            end else begin
                for (int k = 0; k < NBYTES; k++) begin
                    if (cnt_q == CNT_W'(k))
                        stage_d[WORD_W-1-BYTE_W*k -: BYTE_W] = din;
                end
            end
        end
    end

    // Staging register.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    // Byte counter: cleared by update, advances and wraps on byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (upd_evt)            cnt_q <= '0;
        else if (wr_evt && !serial)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign stage = word_t'(stage_q);

    // R6: the counter stays inside the five slots.
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R6: a write to the last slot wraps the counter.
    p_cnt_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && !serial && !upd_evt && cnt_q == LAST) |=> cnt_q == '0);
    // R7: an update clears the counter.
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> cnt_q == '0);
    // R8: serial writes leave the byte counter alone.
    p_ser_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (serial && !upd_evt) |=> $stable(cnt_q));
    // R4: with no write the staged word holds.
    p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_evt |=> $stable(stage_q));
endmodule

// File: rtl/tl_active_reg.sv
// Module: active register and update pulse.
// Assumes upd_evt is a single-cycle event in the clk domain.
module tl_active_reg
    import tl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd_evt,
    input  word_t stage,
    output word_t act,
    output logic  upd_pulse
);
    // Copy the whole staged word in one step on an update.
    always_ff @(posedge clk) begin
        if (!rst_n)       act <= '0;
        else if (upd_evt) act <= stage;
    end

    // Register the update event as the core-facing pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_pulse <= 1'b0;
        else        upd_pulse <= upd_evt;
    end

    // R4: with no update the active word holds.
    p_act_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_evt |=> $stable(act));
    // R5: an update copies the staged word as it was at the event.
    p_act_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> act == $past(stage));
    // R5: the pulse lasts one cycle.
    p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> !upd_pulse);
endmodule

// File: rtl/tuning_loader.sv
// Module: top of the frequency and phase word loader.
// Assumes the host keeps write and update strobes apart and holds din steady around each write.
// Both strobes are synchronized; the format bit of the active control byte picks the loading mode.
module tuning_loader
    import tl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SER_LANE    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_clk,
    input  logic               upd_strobe,
    input  logic [BYTE_W-1:0]  din,
    output logic [FREQ_W-1:0]  freq_word,
    output logic [PHASE_W-1:0] phase_ofs,
    output logic               pwr_down,
    output logic               mult_en,
    output logic               upd_pulse
);
    logic  wr_evt;
    logic  upd_evt;
    word_t stage;
    word_t act;

    tl_edge_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .async_in(wr_clk), .rise(wr_evt)
    );

    tl_edge_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
        .clk(clk), .rst_n(rst_n), .async_in(upd_strobe), .rise(upd_evt)
    );

    tl_load_stage #(.SER_LANE(SER_LANE)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .upd_evt(upd_evt),
        .serial(act.ctrl.fmt_serial), .din(din), .stage(stage)
    );

    tl_active_reg u_active (
        .clk(clk), .rst_n(rst_n), .upd_evt(upd_evt), .stage(stage),
        .act(act), .upd_pulse(upd_pulse)
    );

    assign freq_word = act.freq;
    assign phase_ofs = act.ctrl.phase;
    assign pwr_down  = act.ctrl.pdn;
    assign mult_en   = act.ctrl.mult;

    // R9: the loading format changes only with an update pulse.
    p_fmt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pulse |-> $stable(act.ctrl.fmt_serial));
endmodule

// File: tb/tuning_loader_test.sv
// Bench: sweeps byte loads over all phase values, then wrap, partial, serial and reset cases.
// Keeps its own model of the staged word, the active word, the counter and the mode.
module tuning_loader_test;
    import tl_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_clk = 1'b0;
    logic        upd_strobe = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [31:0] freq_word;
    logic [4:0]  phase_ofs;
    logic        pwr_down;
    logic        mult_en;
    logic        upd_pulse;

    int          n_run = 0;
    int          n_fail = 0;
    logic [39:0] m_stage = '0;
    logic [39:0] m_act = '0;
    int          m_cnt = 0;
    bit          m_ser = 1'b0;

    always #2 clk = ~clk;

    tuning_loader uut (
        .clk(clk), .rst_n(rst_n), .wr_clk(wr_clk), .upd_strobe(upd_strobe),
        .din(din), .freq_word(freq_word), .phase_ofs(phase_ofs),
        .pwr_down(pwr_down), .mult_en(mult_en), .upd_pulse(upd_pulse)
    );

    task automatic check(input string req, input string what,
                         input logic [39:0] actual, input logic [39:0] expct);
        n_run++;
        if (actual !== expct) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, actual, expct);
        end
    endtask

    // Compare all outputs with the model's active word (layout given in R3).
    task automatic check_outputs(input string req);
        check(req,  "freq_word", 40'(freq_word), 40'(m_act[31:0]));
        check("R3", "phase_ofs", 40'(phase_ofs), 40'(m_act[39:35]));
        check("R3", "pwr_down",  40'(pwr_down),  40'(m_act[34]));
        check("R3", "mult_en",   40'(mult_en),   40'(m_act[32]));
    endtask

    // One write strobe, high for 'hold' cycles, then low for three; the model follows.
    task automatic wr_byte(input logic [7:0] d, input int hold);
        @(negedge clk);
        din = d;
        wr_clk = 1'b1;
        repeat (hold) @(negedge clk);
        wr_clk = 1'b0;
        repeat (3) @(negedge clk);
        if (!m_ser) begin
            m_stage[39-8*m_cnt -: 8] = d;
            m_cnt = (m_cnt == 4) ? 0 : m_cnt + 1;
        end else begin
            m_stage = {d[7], m_stage[39:1]};
        end
    endtask

    // Update strobe with latency checks: old outputs before the third edge, new after it.
    task automatic do_update(input string req);
        @(negedge clk);
        upd_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R5", "pulse early", 40'(upd_pulse), 40'd0);
        check_outputs("R4");
        m_act = m_stage;
        m_ser = m_act[33];
        m_cnt = 0;
        @(negedge clk);
        check("R5", "pulse due", 40'(upd_pulse), 40'd1);
        check_outputs(req);
        @(negedge clk);
        check("R5", "pulse width", 40'(upd_pulse), 40'd0);
        upd_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic par_load(input logic [7:0] ctrl, input logic [31:0] f);
        wr_byte(ctrl, 3);
        wr_byte(f[31:24], 3);
        wr_byte(f[23:16], 3);
        wr_byte(f[15:8], 3);
        wr_byte(f[7:0], 3);
    endtask

    // R8/R9: the word goes on din[7]; the other lines carry junk.
    task automatic ser_load(input logic [7:0] ctrl, input logic [31:0] f);
        logic [39:0] w;
        w = {ctrl, f};
        for (int i = 0; i < 40; i++)
            wr_byte({w[i], 7'(i * 37 + 5)}, 3);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        m_stage = '0; m_act = '0; m_cnt = 0; m_ser = 1'b0;
        check_outputs("R1");
        check("R1", "pulse in reset", 40'(upd_pulse), 40'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] f;
        logic [7:0]  c;
        apply_reset();

        // R2/R3: byte loads over every phase value with varied flags.
        for (int i = 0; i < 32; i++) begin
            f = (32'h9E37_79B9 * 32'(i + 1)) ^ (32'(i) << 17);
            c = {5'(i), 1'(i[0] ^ i[1]), 1'b0, 1'(i[2])};
            par_load(c, f);
            do_update("R2");
        end

        // R10: a long write strobe counts as one write.
        wr_byte(8'b01101_1_0_1, 12);
        wr_byte(8'hA5, 3); wr_byte(8'h5A, 3); wr_byte(8'h3C, 3); wr_byte(8'hC3, 3);
        do_update("R10");

        // R6: a sixth byte overwrites the control byte.
        par_load(8'b00011_0_0_1, 32'h1234_5678);
        wr_byte(8'b11100_1_0_0, 3);
        do_update("R6");

        // R7: partial load, update, then the next write is the control byte again.
        wr_byte(8'b10001_0_0_1, 3);
        wr_byte(8'hEE, 3);
        do_update("R7");
        par_load(8'b01010_1_0_0, 32'hCAFE_F00D);
        do_update("R7");

        // R8: enter serial mode, then serial loads that keep it.
        par_load(8'b10101_0_1_1, 32'h0F0F_1234);
        do_update("R9");
        ser_load(8'b00110_1_1_0, 32'h8000_0001);
        do_update("R8");
        ser_load(8'b11011_0_1_1, 32'h7654_3210);
        do_update("R8");

        // R9: serial load with format 0 returns to byte loading.
        ser_load(8'b01111_1_0_1, 32'hDEAD_BEEF);
        do_update("R9");
        par_load(8'b00101_0_0_1, 32'h0BAD_CAB1);
        do_update("R9");

        // R1: reset while in serial mode returns to byte loading.
        par_load(8'b11111_1_1_1, 32'hFFFF_0000);
        do_update("R9");
        apply_reset();
        par_load(8'b10010_0_0_1, 32'h1357_9BDF);
        do_update("R1");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule